// File: doc/BRIEF.md
# Interrupt Pin Conditioner

This block turns an internal interrupt-pending condition into the single external interrupt pin of a host controller. The pending input is expected to be the OR of all event sources that are both enabled and asserted. Configuration inputs come from register fields held elsewhere. One input sets which pin level counts as active. A second input selects held-level or pulsed signalling. A master enable can silence the pin completely. Two further fields give a 16-bit pulse-width count and an 8-bit minimum pulse spacing measured in 125 µs microframes, and a microframe strobe drives that spacing.

In level signalling the pin follows the pending input. In pulsed signalling each accepted event produces one fixed-length pulse. After a pulse begins, no further pulse is allowed until the programmed number of microframe strobes has been seen. Any event that arrives while pulses are blocked is remembered, and it is issued as a single pulse once the pin is free again. The pin is always driven by a flip-flop, so combinational glitches never reach the board.

The register fields live outside the block. Their expected power-up values are: polarity active-low, level signalling, width 0x1F (about 0.5 µs at 60 MHz) and spacing 0.

Top module: `irq_pin_cond`

## Requirements
- R1: While reset is applied, the pin is driven to the inactive level for the current polarity on every clock. The inactive level is the inverse of `cfg_act_high`.
- R2: In level mode (`cfg_pulse_mode`=0) with the enable at 1, the pin is active one clock after `pend_i` is sampled high, and it is inactive one clock after `pend_i` is sampled low.
- R3: With `cfg_enable`=0, the pin is inactive one clock later, whatever the other inputs are. An event that was held back in pulse mode is discarded when the enable is lowered, and it produces no pulse after the enable returns.
- R4: The active pin level equals `cfg_act_high`: 1 means the pin is active high and 0 means it is active low.
- R5: In pulse mode, when a pulse is allowed and `pend_i` is sampled high, the pin is active starting one clock later. It stays active for exactly `cfg_width`+1 clocks and then goes inactive.
- R6: In pulse mode with `cfg_gap`=0 and `pend_i` held high, pulses repeat. Each pulse of `cfg_width`+1 clocks is followed by one inactive clock.
- R7: In pulse mode with `cfg_gap`=G>0, once a pulse starts no new pulse begins until G `uframe_tick_i` strobes have been sampled. A new pulse also needs the current pulse to have ended. The first pulse allowed after that starts one clock after the G-th strobe is sampled.
- R8: In pulse mode, a rising edge on `pend_i` that occurs while pulses are blocked is held, and it is issued as one pulse once they are allowed, even if `pend_i` has since fallen. Several such edges merge into a single pulse.
- R9: The spacing field `cfg_gap` and the microframe strobe have no effect on the pin in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 1 | Enabled-and-asserted event summary |
| uframe_tick_i | input | 1 | One-clock strobe once per 125 µs microframe |
| cfg_act_high | input | 1 | Pin polarity: 1 active high, 0 active low |
| cfg_pulse_mode | input | 1 | Signalling: 0 level, 1 pulsed |
| cfg_enable | input | 1 | Master enable for the pin |
| cfg_width | input | WIDTH_W | Pulse length minus one, in clocks |
| cfg_gap | input | GAP_W | Minimum pulse spacing, in microframes |
| irq_pin_o | output | 1 | Registered interrupt pin |

## Verification
The bench measures pulse length by counting active samples. A design with an off-by-one width counter would give `cfg_width` or `cfg_width`+2 clocks instead of `cfg_width`+1. With a zero spacing and a pending input held high, it checks that pulses keep recurring. A design that fires only on edges would go silent here, and one that never releases the pin would show a continuous level. Short pending blips are sent while the spacing is still running. A design that drops them would give no pulse, and one that queues each blip separately would give two. The last test lowers the enable while an event is held, to catch a design that replays a stale event after the enable returns.

// File: rtl/irq_pin_cond_pkg.sv
package irq_pin_cond_pkg;
  typedef enum logic {
    SIG_LEVEL = 1'b0,
    SIG_PULSE = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             busy,
  output logic             hold_on
);
  logic [CNT_W-1:0] remain_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (fire) begin
      busy_q   <= 1'b1;
      remain_q <= width;
    end else if (busy_q) begin
      if (remain_q == '0) busy_q <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign busy    = busy_q;
  assign hold_on = busy_q && (remain_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    (fire && !clr) |=> busy); // R5
  AST_PULSE_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy && !hold_on && !fire) |=> !busy); // R5
endmodule

// File: rtl/irq_gap_gate.sv
module irq_gap_gate #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_pulse,
  input  logic             pend,
  input  logic             tick,
  input  logic             busy,
  input  logic [GAP_W-1:0] gap,
  output logic             fire
);
  logic             pend_q;
  logic             held_q;
  logic [GAP_W-1:0] gap_left_q;
  logic             rise;
  logic             gap_open;

  assign rise     = pend && !pend_q;
  assign gap_open = (gap_left_q == '0);
  assign fire     = en_pulse && !busy && gap_open && (pend || held_q);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_pulse) held_q <= 1'b0;
    else if (fire)        held_q <= 1'b0;
    else if (rise)        held_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         gap_left_q <= '0;
    else if (fire)                   gap_left_q <= gap;
    else if (tick && !gap_open)      gap_left_q <= gap_left_q - 1'b1;
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R6
  AST_HELD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    fire |=> !held_q); // R8
  AST_HELD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    !en_pulse |=> !held_q); // R3
endmodule

// File: rtl/irq_pin_reg.sv
module irq_pin_reg (
  input  logic clk,
  input  logic rst,
  input  logic act_high,
  input  logic assert_next,
  output logic pin
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= !act_high;
    else     pin_q <= assert_next ? act_high : !act_high;
  end

  assign pin = pin_q;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (pin == !$past(act_high))); // R1
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int WIDTH_W = 16,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pend_i,
  input  logic               uframe_tick_i,
  input  logic               cfg_act_high,
  input  logic               cfg_pulse_mode,
  input  logic               cfg_enable,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic [GAP_W-1:0]   cfg_gap,
  output logic               irq_pin_o
);
  import irq_pin_cond_pkg::*;

  sig_mode_e mode;
  logic      en_pulse;
  logic      fire;
  logic      busy;
  logic      hold_on;
  logic      assert_next;

  assign mode     = sig_mode_e'(cfg_pulse_mode);
  assign en_pulse = cfg_enable && (mode == SIG_PULSE);

  irq_gap_gate #(.GAP_W(GAP_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .en_pulse (en_pulse),
    .pend     (pend_i),
    .tick     (uframe_tick_i),
    .busy     (busy),
    .gap      (cfg_gap),
    .fire     (fire)
  );

  irq_pulse_timer #(.CNT_W(WIDTH_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (!en_pulse),
    .fire    (fire),
    .width   (cfg_width),
    .busy    (busy),
    .hold_on (hold_on)
  );

  always_comb begin
    if (!cfg_enable)             assert_next = 1'b0;
    else if (mode == SIG_LEVEL)  assert_next = pend_i;
    else                         assert_next = fire || hold_on;
  end

  irq_pin_reg u_pin (
    .clk         (clk),
    .rst         (rst),
    .act_high    (cfg_act_high),
    .assert_next (assert_next),
    .pin         (irq_pin_o)
  );

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (irq_pin_o == !$past(cfg_act_high))); // R3
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && !cfg_pulse_mode) |=>
      (irq_pin_o == ($past(pend_i) ? $past(cfg_act_high) : !$past(cfg_act_high)))); // R2
  AST_PULSE_BEGIN: assert property (@(posedge clk) disable iff (rst)
    fire |=> (irq_pin_o == $past(cfg_act_high))); // R5
endmodule

// File: tb/irq_pin_cond_tb.sv
module irq_pin_cond_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_W = 16;
  localparam int GAP_W   = 8;
  // bits: {act_high, enable, pend, expected pin}, level mode, gap nonzero (R9)
  localparam logic [3:0] LVL_VEC [0:9] = '{
    4'b1111, 4'b1100, 4'b1010, 4'b0110, 4'b0101,
    4'b0011, 4'b1111, 4'b1000, 4'b0110, 4'b1111
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pend = 1'b0;
  logic tick = 1'b0;
  logic act_high = 1'b0;
  logic pmode = 1'b0;
  logic en = 1'b0;
  logic [WIDTH_W-1:0] width = 16'h001F;
  logic [GAP_W-1:0]   gap = '0;
  logic pin;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_cond #(.WIDTH_W(WIDTH_W), .GAP_W(GAP_W)) u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .uframe_tick_i(tick),
    .cfg_act_high(act_high), .cfg_pulse_mode(pmode), .cfg_enable(en),
    .cfg_width(width), .cfg_gap(gap), .irq_pin_o(pin)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int is_act();
    return (pin == act_high) ? 1 : 0;
  endfunction

  task automatic count_act(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      c += is_act();
    end
  endtask

  initial begin
    int c;
    // R1: reset state for both polarities
    cyc(); cyc();
    chk("R1 idle high while active-low", pin, 1);
    act_high = 1'b1;
    cyc();
    chk("R1 idle low while active-high", pin, 0);
    rst = 1'b0;
    en = 1'b1;
    gap = 8'd7;
    // R2 R3 R4 R9: level-mode vector walk with spacing set and strobes toggling
    for (int v = 0; v < 10; v++) begin
      act_high = LVL_VEC[v][3];
      en       = LVL_VEC[v][2];
      pend     = LVL_VEC[v][1];
      tick     = v[0];
      cyc();
      chk($sformatf("R2/R3/R4/R9 vec%0d", v), pin, LVL_VEC[v][0]);
    end
    tick = 1'b0;
    // R5: pulse width 3 -> 4 clocks active
    pend = 1'b0; act_high = 1'b1; en = 1'b1; gap = '0; width = 16'd3;
    cyc();
    pmode = 1'b1;
    cyc(); cyc();
    pend = 1'b1;
    cyc();
    pend = 1'b0;
    c = is_act();
    chk("R5 pulse starts one clock after edge", c, 1);
    begin int r; count_act(19, r); c += r; end
    chk("R5 pulse length width+1", c, 4);
    // R6: spacing zero, pend held, width 1 -> 2 on, 1 off
    width = 16'd1;
    pend = 1'b1;
    count_act(12, c);
    chk("R6 repeating pulses", c, 8);
    pend = 1'b0;
    repeat (4) cyc();
    // R7: spacing 2, width 0, active-low pin
    act_high = 1'b0; width = '0; gap = 8'd2;
    cyc();
    pend = 1'b1;
    count_act(8, c);
    chk("R7 only one pulse before strobes", c, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 blocked after first strobe", is_act(), 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 not yet active on second strobe", is_act(), 0);
    cyc();
    chk("R7 pulse one clock after last strobe", is_act(), 1);
    count_act(4, c);
    chk("R7 single pulse after spacing", c, 0);
    pend = 1'b0;
    repeat (3) begin tick = 1'b1; cyc(); tick = 1'b0; cyc(); end
    // R8: spacing 1, held edges merge
    act_high = 1'b1; gap = 8'd1;
    cyc();
    pend = 1'b1; cyc(); pend = 1'b0;
    chk("R8 first blip fires", is_act(), 1);
    c = 0;
    cyc(); c += is_act();
    pend = 1'b1; cyc(); c += is_act(); pend = 1'b0;
    cyc(); c += is_act();
    pend = 1'b1; cyc(); c += is_act(); pend = 1'b0;
    cyc(); c += is_act();
    chk("R8 no pulse while spacing runs", c, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    begin int r; count_act(6, r); c += r; end
    chk("R8 held edges give one pulse", c, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    count_act(6, c);
    chk("R8 no second pulse from merged edges", c, 0);
    // R3: held event dropped by disable
    pend = 1'b1; cyc(); pend = 1'b0;
    chk("R3 setup pulse fires", is_act(), 1);
    cyc();
    pend = 1'b1; cyc(); pend = 1'b0;
    en = 1'b0;
    cyc();
    chk("R3 inactive when disabled", is_act(), 0);
    en = 1'b1;
    tick = 1'b1; cyc(); tick = 1'b0;
    count_act(6, c);
    chk("R3 held event discarded", c, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule